// File: doc/BRIEF.md
# Interrupt Distributor With Routing

This block collects up to a few dozen interrupt requests in a small multi-core system. It turns each request into a per-interrupt pending flag, and for every CPU interface it selects the most urgent request that may be delivered there. It keeps five pieces of state for each interrupt: enable, pending, active, a priority and a CPU route mask. Software reaches all of it through a word-addressed register port. The enable, pending and active bits are changed through pairs of set and clear words.

Interrupt IDs fall into three classes.
- IDs 0 to 15 are raised only by software.
- IDs 16 to 31 are private to a CPU. Their trigger type and route are fixed.
- IDs 32 and up are shared. Their trigger type and route can be programmed.

Each CPU interface gets a registered (valid, ID, priority) triple. When the CPU takes the interrupt it sends back an acknowledge pulse, which marks that interrupt active. When it has finished, it returns a deactivate pulse together with the ID.

Top module: `irq_distributor`

## Requirements
- R1: IDs 0-15 are software-only: their `irq_src` bits are ignored. IDs 16-31 are private and are always routed to CPU 0 only. IDs 32 and up are shared.
- R2: Trigger fields are 2 bits per ID. They sit at word 45 + ID/16, bits [2*(ID%16)+1 : 2*(ID%16)]. IDs 0-15 always read 2'b10 (edge) and IDs 16-31 always read 2'b01 (level). Writes to these fields are ignored.
- R3: For a shared ID, bit 0 of the trigger field always reads 1 and bit 1 is writable. The reset value is 2'b01, which means active-high level. The value 2'b11 means rising edge.
- R4: A level ID is pending while its input is high. An edge ID latches pending on a 0-to-1 input transition and holds it until an acknowledge or a pending-clear.
- R5: Route masks are at word 29 + ID/4, byte ID%4. Bit c of the mask selects CPU c. Shared masks are writable and reset to 0x01. IDs 16-31 read 0x01. IDs 0-31 ignore writes.
- R6: Priorities are at word 13 + ID/4, byte ID%4. Only the upper nibble of each byte is stored, and the lower nibble reads 0. Priorities reset to 0. A smaller value means a more urgent interrupt.
- R7: The state words come in set/clear pairs, each pair holding IDs 32w to 32w+31 in bit ID%32 of word w.
  - Enable: set at word 1+w, clear at word 3+w.
  - Pending: set at word 5+w, clear at word 7+w.
  - Active: set at word 9+w, clear at word 11+w.
  
  Writing a 1 to a bit performs the action on that ID. Writing a 0 leaves the ID unchanged. Both words of a pair read back the current state.
- R8: Control word 0, bit 0, is the global enable. It resets to 0. While it is 0, no CPU receives a valid forward.
- R9: For each CPU the block forwards one interrupt that is enabled, pending, not active and routed to that CPU.
  - The interrupt with the smallest priority value wins. On equal priority, the lower ID wins.
  - `cpu_fwd_prio` is the full 8-bit priority byte.
  - When no interrupt qualifies, the outputs are valid 0, ID 1023 and priority 0xFF.
- R10: Setting the pending bit of an ID 0-15 latches the CPU mask held in word 49, bits [7:0], as that ID's route. The route reads back at that ID's route byte.
- R11: An acknowledge pulse on CPU c marks the ID forwarded to CPU c as active and clears its latched pending bit. A deactivate pulse clears the active bit of `cpu_deact_id[c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_IDS | Interrupt request inputs, one per ID |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cpu_fwd_valid | output | NUM_CPUS | An interrupt is forwarded to CPU c |
| cpu_fwd_id | output | NUM_CPUS x 10 | Forwarded ID, 1023 when none |
| cpu_fwd_prio | output | NUM_CPUS x 8 | Forwarded priority byte, 0xFF when none |
| cpu_ack | input | NUM_CPUS | Acknowledge pulse from CPU c |
| cpu_deact | input | NUM_CPUS | Deactivate pulse from CPU c |
| cpu_deact_id | input | NUM_CPUS x 10 | ID to deactivate for CPU c |

## Verification
Timing depends on the stimulus.
- A level input reaches the forward outputs at the first clock edge after it settles.
- A register write, an edge detection, an acknowledge or a deactivate first updates state at one edge. The forward outputs then follow at the next edge.
- Reads are combinational.

The scoreboard driver holds every input still for three cycles before it posts an expectation. The monitor compares one nanosecond after the following rising edge, so every result is sampled once it has certainly settled and before the next stimulus.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;
  localparam int SGI_TOP = 15;
  localparam int PPI_TOP = 31;
  localparam logic [7:0] PPI_ROUTE = 8'h01;
  localparam logic [7:0] SPI_ROUTE_RST = 8'h01;

  // register regions, in address order
  localparam int RG_CTRL = 0;
  localparam int RG_ENS = 1;
  localparam int RG_ENC = 2;
  localparam int RG_PNS = 3;
  localparam int RG_PNC = 4;
  localparam int RG_ACS = 5;
  localparam int RG_ACC = 6;
  localparam int RG_PRI = 7;
  localparam int RG_TGT = 8;
  localparam int RG_TRG = 9;
  localparam int RG_SGM = 10;

  typedef enum logic [1:0] {CLS_SGI, CLS_PPI, CLS_SPI} id_class_e;

  function automatic id_class_e class_of(int id);
    if (id <= SGI_TOP) return CLS_SGI;
    if (id <= PPI_TOP) return CLS_PPI;
    return CLS_SPI;
  endfunction

  // trigger code: bit1 = edge, bit0 = level flavour bit
  function automatic logic [1:0] trig_code(int id, logic edge_sel);
    case (class_of(id))
      CLS_SGI: return 2'b10;
      CLS_PPI: return 2'b01;
      default: return {edge_sel, 1'b1};
    endcase
  endfunction

  // first word of a register region for a distributor with n IDs
  function automatic int base_of(int rg, int n);
    int nw;
    nw = n / 32;
    case (rg)
      RG_CTRL: return 0;
      RG_ENS:  return 1;
      RG_ENC:  return 1 + nw;
      RG_PNS:  return 1 + 2 * nw;
      RG_PNC:  return 1 + 3 * nw;
      RG_ACS:  return 1 + 4 * nw;
      RG_ACC:  return 1 + 5 * nw;
      RG_PRI:  return 1 + 6 * nw;
      RG_TGT:  return 1 + 6 * nw + n / 4;
      RG_TRG:  return 1 + 6 * nw + n / 2;
      default: return 1 + 6 * nw + n / 2 + n / 16;
    endcase
  endfunction

  function automatic logic [7:0] prio_byte(logic [7:0] stored, int bits);
    return 8'(stored << (8 - bits));
  endfunction
endpackage

// File: rtl/irqd_cfg.sv
module irqd_cfg
  import irqd_pkg::*;
#(
  parameter int NUM_IDS   = 64,
  parameter int NUM_CPUS  = 2,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] wdata,
  input  logic [SGI_TOP:0] sgi_set_i,
  output logic glob_en_o,
  output logic [NUM_IDS-1:0] edge_o,
  output logic [NUM_IDS-1:0][PRIO_BITS-1:0] prio_o,
  output logic [NUM_IDS-1:0][NUM_CPUS-1:0] route_o,
  output logic [31:0] rdata_o
);
  localparam int A_CTRL = base_of(RG_CTRL, NUM_IDS);
  localparam int A_PRI  = base_of(RG_PRI, NUM_IDS);
  localparam int A_TGT  = base_of(RG_TGT, NUM_IDS);
  localparam int A_TRG  = base_of(RG_TRG, NUM_IDS);
  localparam int A_SGM  = base_of(RG_SGM, NUM_IDS);
  localparam int LOW_LSB = 8 - PRIO_BITS;

  logic en_q;
  logic [7:0] sgm_q;
  logic [NUM_IDS-1:0][PRIO_BITS-1:0] prio_q;
  logic [NUM_IDS-1:PPI_TOP+1][7:0] tgt_q;
  logic [NUM_IDS-1:PPI_TOP+1] trg_hi_q;
  logic [SGI_TOP:0][7:0] route_q;
  logic [NUM_IDS-1:0][1:0] trg_w;
  logic [NUM_IDS-1:0][7:0] tgt_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      sgm_q    <= '0;
      prio_q   <= '0;
      tgt_q    <= {(NUM_IDS-PPI_TOP-1){SPI_ROUTE_RST}};
      trg_hi_q <= '0;
      route_q  <= '0;
    end else begin
      for (int s = 0; s <= SGI_TOP; s++)
        if (sgi_set_i[s]) route_q[s] <= sgm_q;
      if (wr_en) begin
        if (addr == ADDR_W'(A_CTRL)) en_q <= wdata[0];
        if (addr == ADDR_W'(A_SGM)) sgm_q <= wdata[7:0];
        for (int i = 0; i < NUM_IDS; i++)
          if (addr == ADDR_W'(A_PRI + i / 4))
            prio_q[i] <= wdata[8*(i%4)+LOW_LSB +: PRIO_BITS];
        for (int i = PPI_TOP + 1; i < NUM_IDS; i++) begin
          if (addr == ADDR_W'(A_TGT + i / 4)) tgt_q[i] <= wdata[8*(i%4) +: 8];
          if (addr == ADDR_W'(A_TRG + i / 16)) trg_hi_q[i] <= wdata[2*(i%16)+1];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_id
    if (g <= SGI_TOP) begin : g_sgi
      assign trg_w[g] = trig_code(g, 1'b0);
      assign tgt_w[g] = route_q[g];
    end else if (g <= PPI_TOP) begin : g_ppi
      assign trg_w[g] = trig_code(g, 1'b0);
      assign tgt_w[g] = PPI_ROUTE;
    end else begin : g_spi
      assign trg_w[g] = trig_code(g, trg_hi_q[g]);
      assign tgt_w[g] = tgt_q[g];
    end
    assign edge_o[g]  = trg_w[g][1];
    assign route_o[g] = tgt_w[g][NUM_CPUS-1:0];
  end

  assign glob_en_o = en_q;
  assign prio_o    = prio_q;

  always_comb begin
    rdata_o = '0;
    if (addr == ADDR_W'(A_CTRL)) rdata_o[0] = en_q;
    if (addr == ADDR_W'(A_SGM)) rdata_o[7:0] = sgm_q;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (addr == ADDR_W'(A_PRI + i / 4))
        rdata_o[8*(i%4) +: 8] = prio_byte(8'(prio_q[i]), PRIO_BITS);
      if (addr == ADDR_W'(A_TGT + i / 4)) rdata_o[8*(i%4) +: 8] = tgt_w[i];
      if (addr == ADDR_W'(A_TRG + i / 16)) rdata_o[2*(i%16) +: 2] = trg_w[i];
    end
  end
endmodule

// File: rtl/irqd_state.sv
module irqd_state
  import irqd_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int ADDR_W  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] wdata,
  input  logic [NUM_IDS-1:0] src_i,
  input  logic [NUM_IDS-1:0] edge_i,
  input  logic [NUM_IDS-1:0] ack_set_i,
  input  logic [NUM_IDS-1:0] deact_clr_i,
  output logic [NUM_IDS-1:0] en_o,
  output logic [NUM_IDS-1:0] pend_o,
  output logic [NUM_IDS-1:0] act_o,
  output logic [SGI_TOP:0] sgi_set_o,
  output logic [31:0] rdata_o
);
  localparam int NW    = NUM_IDS / 32;
  localparam int A_ENS = base_of(RG_ENS, NUM_IDS);
  localparam int A_ENC = base_of(RG_ENC, NUM_IDS);
  localparam int A_PNS = base_of(RG_PNS, NUM_IDS);
  localparam int A_PNC = base_of(RG_PNC, NUM_IDS);
  localparam int A_ACS = base_of(RG_ACS, NUM_IDS);
  localparam int A_ACC = base_of(RG_ACC, NUM_IDS);
  localparam logic [NUM_IDS-1:0] SRC_USE = {{(NUM_IDS-SGI_TOP-1){1'b1}}, {(SGI_TOP+1){1'b0}}};

  logic [NUM_IDS-1:0] ens, enc, pns, pnc, acs, acc;
  logic [NUM_IDS-1:0] en_q, latch_q, act_q, src_q, src_u, rise;
  logic [NUM_IDS-1:0] act_up, act_dn, latch_clr, latch_keep;

  always_comb begin
    {ens, enc, pns, pnc, acs, acc} = '0;
    for (int w = 0; w < NW; w++) begin
      if (wr_en && addr == ADDR_W'(A_ENS + w)) ens[w*32 +: 32] = wdata;
      if (wr_en && addr == ADDR_W'(A_ENC + w)) enc[w*32 +: 32] = wdata;
      if (wr_en && addr == ADDR_W'(A_PNS + w)) pns[w*32 +: 32] = wdata;
      if (wr_en && addr == ADDR_W'(A_PNC + w)) pnc[w*32 +: 32] = wdata;
      if (wr_en && addr == ADDR_W'(A_ACS + w)) acs[w*32 +: 32] = wdata;
      if (wr_en && addr == ADDR_W'(A_ACC + w)) acc[w*32 +: 32] = wdata;
    end
  end

  assign src_u      = src_i & SRC_USE;
  assign rise       = src_u & ~src_q & edge_i;
  assign act_up     = acs | ack_set_i;
  assign act_dn     = acc | deact_clr_i;
  assign latch_clr  = pnc & ~pns & ~rise;
  assign latch_keep = latch_q & edge_i & ~pnc & ~ack_set_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      latch_q <= '0;
      act_q   <= '0;
      src_q   <= '0;
    end else begin
      src_q   <= src_u;
      en_q    <= (en_q | ens) & ~enc;
      latch_q <= (latch_q & ~pnc & ~ack_set_i) | pns | rise;
      act_q   <= (act_q | act_up) & ~act_dn;
    end
  end

  assign en_o      = en_q;
  assign pend_o    = latch_q | (src_u & ~edge_i);
  assign act_o     = act_q;
  assign sgi_set_o = pns[SGI_TOP:0];

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (addr == ADDR_W'(A_ENS + w) || addr == ADDR_W'(A_ENC + w)) rdata_o = en_q[w*32 +: 32];
      if (addr == ADDR_W'(A_PNS + w) || addr == ADDR_W'(A_PNC + w)) rdata_o = pend_o[w*32 +: 32];
      if (addr == ADDR_W'(A_ACS + w) || addr == ADDR_W'(A_ACC + w)) rdata_o = act_q[w*32 +: 32];
    end
  end

  AST_ACTIVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    |(act_up & ~act_dn) |=> ((act_q & $past(act_up & ~act_dn)) == $past(act_up & ~act_dn))); // R11
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    |latch_clr |=> ((latch_q & $past(latch_clr)) == '0)); // R7
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    |latch_keep |=> ((latch_q & $past(latch_keep)) == $past(latch_keep))); // R4
endmodule

// File: rtl/irqd_arb.sv
module irqd_arb
  import irqd_pkg::*;
#(
  parameter int NUM_IDS   = 64,
  parameter int PRIO_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_IDS-1:0] cand_i,
  input  logic [NUM_IDS-1:0][PRIO_BITS-1:0] prio_i,
  output logic fwd_valid_o,
  output logic [ID_W-1:0] fwd_id_o,
  output logic [7:0] fwd_prio_o
);
  logic win_v;
  logic [ID_W-1:0] win_id;
  logic [PRIO_BITS-1:0] win_p;

  // ascending scan with strict compare: ties keep the lower ID
  always_comb begin
    win_v  = 1'b0;
    win_id = ID_NONE;
    win_p  = '1;
    for (int i = 0; i < NUM_IDS; i++)
      if (cand_i[i] && (!win_v || prio_i[i] < win_p)) begin
        win_v  = 1'b1;
        win_id = ID_W'(i);
        win_p  = prio_i[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid_o <= 1'b0;
      fwd_id_o    <= ID_NONE;
      fwd_prio_o  <= 8'hFF;
    end else begin
      fwd_valid_o <= win_v;
      fwd_id_o    <= win_v ? win_id : ID_NONE;
      fwd_prio_o  <= win_v ? prio_byte(8'(win_p), PRIO_BITS) : 8'hFF;
    end
  end

  AST_NO_RESERVED_ID: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid_o |-> (fwd_id_o < ID_W'(NUM_IDS))); // R9
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid_o |-> (fwd_id_o == ID_NONE && fwd_prio_o == 8'hFF)); // R9
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int NUM_IDS   = 64,
  parameter int NUM_CPUS  = 2,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_IDS-1:0] irq_src,
  input  logic reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [NUM_CPUS-1:0] cpu_fwd_valid,
  output logic [NUM_CPUS-1:0][ID_W-1:0] cpu_fwd_id,
  output logic [NUM_CPUS-1:0][7:0] cpu_fwd_prio,
  input  logic [NUM_CPUS-1:0] cpu_ack,
  input  logic [NUM_CPUS-1:0] cpu_deact,
  input  logic [NUM_CPUS-1:0][ID_W-1:0] cpu_deact_id
);
  logic glob_en;
  logic [NUM_IDS-1:0] edge_m, en, pend, act, ack_set, deact_clr;
  logic [NUM_IDS-1:0][PRIO_BITS-1:0] prio;
  logic [NUM_IDS-1:0][NUM_CPUS-1:0] route;
  logic [SGI_TOP:0] sgi_set;
  logic [31:0] cfg_rd, st_rd;

  irqd_cfg #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .sgi_set_i(sgi_set), .glob_en_o(glob_en), .edge_o(edge_m), .prio_o(prio),
    .route_o(route), .rdata_o(cfg_rd));

  irqd_state #(.NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .src_i(irq_src), .edge_i(edge_m), .ack_set_i(ack_set), .deact_clr_i(deact_clr),
    .en_o(en), .pend_o(pend), .act_o(act), .sgi_set_o(sgi_set), .rdata_o(st_rd));

  assign reg_rdata = cfg_rd | st_rd;

  always_comb begin
    ack_set   = '0;
    deact_clr = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      for (int i = 0; i < NUM_IDS; i++) begin
        if (cpu_ack[c] && cpu_fwd_valid[c] && cpu_fwd_id[c] == ID_W'(i)) ack_set[i] = 1'b1;
        if (cpu_deact[c] && cpu_deact_id[c] == ID_W'(i)) deact_clr[i] = 1'b1;
      end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_IDS-1:0] cand;
    always_comb
      for (int i = 0; i < NUM_IDS; i++)
        cand[i] = glob_en & en[i] & pend[i] & ~act[i] & route[i][c];

    irqd_arb #(.NUM_IDS(NUM_IDS), .PRIO_BITS(PRIO_BITS)) u_arb (
      .clk(clk), .rst_n(rst_n), .cand_i(cand), .prio_i(prio),
      .fwd_valid_o(cpu_fwd_valid[c]), .fwd_id_o(cpu_fwd_id[c]), .fwd_prio_o(cpu_fwd_prio[c]));
  end

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> (cpu_fwd_valid == '0)); // R8
endmodule

// File: tb/irq_distributor_tb_top.sv
module irq_distributor_tb_top;
  localparam int N = 64;
  localparam int NC = 2;
  // register map restated from the requirements
  localparam int W_CTRL = 0, W_ENS = 1, W_ENC = 3, W_PNS = 5, W_PNC = 7;
  localparam int W_ACS = 9, W_ACC = 11, W_PRI = 13, W_TGT = 29, W_TRG = 45, W_SGM = 49;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_src = '0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC-1:0] cpu_fwd_valid;
  logic [NC-1:0][9:0] cpu_fwd_id;
  logic [NC-1:0][7:0] cpu_fwd_prio;
  logic [NC-1:0] cpu_ack = '0;
  logic [NC-1:0] cpu_deact = '0;
  logic [NC-1:0][9:0] cpu_deact_id = '0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  typedef struct {int cpu; bit v; int id; int pr; string tag;} exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  irq_distributor dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_fwd_valid(cpu_fwd_valid),
    .cpu_fwd_id(cpu_fwd_id), .cpu_fwd_prio(cpu_fwd_prio), .cpu_ack(cpu_ack),
    .cpu_deact(cpu_deact), .cpu_deact_id(cpu_deact_id));

  // monitor: pops expectations one ns after a rising edge
  initial forever begin
    @(posedge clk);
    #1;
    while (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      n_checks++;
      if (cpu_fwd_valid[e.cpu] !== e.v || cpu_fwd_id[e.cpu] !== 10'(e.id) ||
          cpu_fwd_prio[e.cpu] !== 8'(e.pr)) begin
        n_errors++;
        $display("FAIL %s cpu%0d: got v=%0b id=%0d prio=%0h, expected v=%0b id=%0d prio=%0h",
                 e.tag, e.cpu, cpu_fwd_valid[e.cpu], cpu_fwd_id[e.cpu], cpu_fwd_prio[e.cpu],
                 e.v, e.id, e.pr);
      end
    end
  end

  task automatic post1(input int cpu, input bit v, input int id, input int pr, input string tag);
    exp_t e;
    e.cpu = cpu; e.v = v; e.id = v ? id : 1023; e.pr = v ? pr : 255; e.tag = tag;
    sbq.push_back(e);
  endtask

  // driver: settle, post both CPUs, hold until the monitor has compared
  task automatic expect_fwd(input bit v0, input int id0, input int p0,
                            input bit v1, input int id1, input int p1, input string tag);
    repeat (3) @(negedge clk);
    post1(0, v0, id0, p0, tag);
    post1(1, v1, id1, p1, tag);
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = 6'(a);
    #1;
    n_checks++;
    if (reg_rdata !== exp) begin
      n_errors++;
      $display("FAIL %s word %0d: got %08h expected %08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic pulse_ack(input int c);
    @(negedge clk); cpu_ack[c] = 1'b1;
    @(negedge clk); cpu_ack[c] = 1'b0;
  endtask

  task automatic pulse_deact(input int c, input int id);
    @(negedge clk); cpu_deact[c] = 1'b1; cpu_deact_id[c] = 10'(id);
    @(negedge clk); cpu_deact[c] = 1'b0;
  endtask

  task automatic src_set(input int id, input logic v);
    @(negedge clk); irq_src[id] = v;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd_chk(W_CTRL, 32'h0, "R8 reset control");
    rd_chk(W_TRG, 32'hAAAAAAAA, "R2 SGI trigger reset");
    rd_chk(W_TRG + 1, 32'h55555555, "R2 private trigger reset");
    rd_chk(W_TRG + 2, 32'h55555555, "R3 shared trigger reset");
    rd_chk(W_TGT + 4, 32'h01010101, "R5 private route");
    rd_chk(W_TGT + 8, 32'h01010101, "R5 shared route reset");
    expect_fwd(0, 0, 0, 0, 0, 0, "R9 reset idle");
    // fixed fields ignore writes
    wr(W_TRG, 32'h0); wr(W_TRG + 1, 32'h0);
    rd_chk(W_TRG, 32'hAAAAAAAA, "R2 SGI trigger write ignored");
    rd_chk(W_TRG + 1, 32'h55555555, "R2 private trigger write ignored");
    wr(W_TGT + 4, 32'hFFFFFFFF);
    rd_chk(W_TGT + 4, 32'h01010101, "R5 private route write ignored");
    // priority nibbles
    wr(W_PRI + 8, 32'h12345678);
    rd_chk(W_PRI + 8, 32'h10305070, "R6 priority low nibble");
    // shared trigger bit1 writable
    wr(W_TRG + 2, 32'hFFFFFFFF);
    rd_chk(W_TRG + 2, 32'hFFFFFFFF, "R3 shared trigger edge");
    wr(W_TRG + 2, 32'h0);
    rd_chk(W_TRG + 2, 32'h55555555, "R3 shared trigger bit0 stays 1");
    wr(W_TRG + 2, 32'h00020000);
    rd_chk(W_TRG + 2, 32'h55575555, "R3 id40 edge");
    // level id33, prio 5
    wr(W_CTRL, 32'h1);
    wr(W_ENS + 1, 32'h2);
    src_set(33, 1'b1);
    expect_fwd(1, 33, 'h50, 0, 0, 0, "R4 level pending forwarded");
    src_set(33, 1'b0);
    expect_fwd(0, 0, 0, 0, 0, 0, "R4 level follows input");
    src_set(33, 1'b1);
    wr(W_CTRL, 32'h0);
    expect_fwd(0, 0, 0, 0, 0, 0, "R8 global enable off");
    wr(W_CTRL, 32'h1);
    expect_fwd(1, 33, 'h50, 0, 0, 0, "R8 global enable on");
    // priority order and tie
    wr(W_ENS + 1, 32'h4);
    src_set(34, 1'b1);
    expect_fwd(1, 34, 'h30, 0, 0, 0, "R9 smaller priority wins");
    wr(W_PRI + 8, 32'h12565678);
    rd_chk(W_PRI + 8, 32'h10505070, "R6 priority rewrite");
    expect_fwd(1, 33, 'h50, 0, 0, 0, "R9 tie lower ID wins");
    // routing id34 to CPU 1
    wr(W_TGT + 8, 32'h01020101);
    rd_chk(W_TGT + 8, 32'h01020101, "R5 shared route write");
    expect_fwd(1, 33, 'h50, 1, 34, 'h50, "R5 route to cpu1");
    // edge id40
    wr(W_ENS + 1, 32'h100);
    src_set(40, 1'b1);
    src_set(40, 1'b0);
    expect_fwd(1, 40, 'h00, 1, 34, 'h50, "R4 edge latched after input drop");
    rd_chk(W_PNS + 1, 32'h106, "R4 pending read");
    // acknowledge / deactivate
    pulse_ack(0);
    expect_fwd(1, 33, 'h50, 1, 34, 'h50, "R11 ack makes active");
    rd_chk(W_ACS + 1, 32'h100, "R11 active bit");
    rd_chk(W_PNC + 1, 32'h006, "R11 ack clears latch");
    pulse_deact(0, 40);
    rd_chk(W_ACC + 1, 32'h0, "R11 deactivate");
    expect_fwd(1, 33, 'h50, 1, 34, 'h50, "R11 after deactivate");
    // pending set / clear pair
    wr(W_PNS + 1, 32'h100);
    expect_fwd(1, 40, 'h00, 1, 34, 'h50, "R7 pending set");
    wr(W_PNC + 1, 32'h0);
    expect_fwd(1, 40, 'h00, 1, 34, 'h50, "R7 zero write no effect");
    wr(W_PNC + 1, 32'h100);
    expect_fwd(1, 33, 'h50, 1, 34, 'h50, "R7 pending clear");
    wr(W_ENC + 1, 32'h2);
    rd_chk(W_ENS + 1, 32'h104, "R7 enable clear");
    expect_fwd(0, 0, 0, 1, 34, 'h50, "R7 disabled id not forwarded");
    wr(W_ACS + 1, 32'h4);
    expect_fwd(0, 0, 0, 0, 0, 0, "R7 active set masks");
    wr(W_ACC + 1, 32'h4);
    expect_fwd(0, 0, 0, 1, 34, 'h50, "R7 active clear");
    // software IDs
    src_set(34, 1'b0);
    wr(W_ENS, 32'h8);
    src_set(3, 1'b1);
    expect_fwd(0, 0, 0, 0, 0, 0, "R1 SGI input ignored");
    rd_chk(W_PNS, 32'h0, "R1 SGI input not pending");
    wr(W_SGM, 32'h2);
    wr(W_PNS, 32'h8);
    rd_chk(W_TGT, 32'h02000000, "R10 SGI route latched");
    expect_fwd(0, 0, 0, 1, 3, 'h00, "R10 SGI to masked cpu");
    pulse_ack(1);
    expect_fwd(0, 0, 0, 0, 0, 0, "R11 SGI acknowledged");
    pulse_deact(1, 3);
    expect_fwd(0, 0, 0, 0, 0, 0, "R11 SGI deactivated");
    // private ID fixed route
    wr(W_ENS, 32'h00100000);
    src_set(20, 1'b1);
    expect_fwd(1, 20, 'h00, 0, 0, 0, "R1 private routed to cpu0");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule